// File: doc/BRIEF.md
# Termination Impedance Calibration Controller

This block sequences the digital side of an on-chip termination calibration. A replica of the termination is fed from a reference current, and a comparator reports whether the replica's voltage has fallen to the level across an external precision resistor. The controller steers the reference current and the comparator input to one replica at a time, starting with the receive replica and then the transmit replica. In each phase it sweeps a 6-bit trim code upward from zero (highest replica resistance) one step at a time until the comparator trips.

At the trip, the current code is written into that phase's holding register. The receive result drives the real receive termination. The transmit result is found on the pull-down replica alone and is applied to both the pull-down and the pull-up driver arrays. A programmable settle delay follows every code change. The raw comparator passes through a two-flop synchronizer and must read high twice in a row to count. A sweep that reaches all ones without a trip stores all ones and raises a sticky range flag.

Top module: `termcal_ctrl`

## Requirements
- R1: While reset is high and after it is released, busy, done and range_error are 0, steer_sel is 3'b000, cmp_tap_sel is 2'b00, and cal_code, rx_term_code, tx_pd_code and tx_pu_code are all zero.
- R2: A start seen while idle gives a one-cycle code_clr pulse, after which all three held codes and range_error read 0. During the receive phase steer_sel is 3'b001 and cmp_tap_sel is 2'b01. During the transmit phase they are 3'b010 and 2'b10. Whenever busy is low they are 3'b000 and 2'b00.
- R3: Each phase's sweep starts at code 0 and advances by exactly +1 per step. A step lasts settle_len cycles (a value of 0 acts as 1) plus one evaluation cycle. Busy stays high for 3 + (Nrx + Ntx) * (settle + 1) cycles, where N is the number of codes evaluated in that phase. cal_code is 0 whenever busy is low.
- R4: With settle_len of at least 4, the stored code of a phase is the lowest code at which the comparator reads 1.
- R5: The comparator counts as tripped only when two consecutive synchronized samples are 1. A comparator pulse lasting one clock cycle does not stop the sweep.
- R6: The receive result appears on rx_term_code. The transmit result appears on both tx_pd_code and tx_pu_code.
- R7: If a phase reaches code 63 without a trip, 63 is stored for it, range_error is set, and the sequence continues. range_error stays 1 until reset or the next accepted start.
- R8: code_wr pulses exactly twice per run, once for each phase, with the receive phase first. done is a single-cycle pulse after both writes, and busy is low in that cycle.
- R9: A start asserted while busy is high is ignored. The run's timing and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (taken only when idle) |
| cmp_in | input | 1 | Asynchronous comparator output, 1 when the replica voltage has reached the reference |
| settle_len | input | 4 | Settle cycles after each code change (0 acts as 1) |
| busy | output | 1 | High for the whole run |
| done | output | 1 | One-cycle pulse at the end of a run |
| range_error | output | 1 | Sticky flag: a phase swept to all ones without a trip |
| steer_sel | output | 3 | Current branch select: 000 off, 001 receive replica, 010 transmit replica |
| cmp_tap_sel | output | 2 | Comparator input select, one-hot: 01 receive, 10 transmit, 00 none |
| cal_code | output | 6 | Live trim code applied to the active replica |
| code_clr | output | 1 | Clear strobe for the code holding registers |
| code_wr | output | 1 | Write strobe for the code holding registers |
| rx_term_code | output | 6 | Held receive termination code |
| tx_pd_code | output | 6 | Held transmit code for the pull-down array |
| tx_pu_code | output | 6 | Held transmit code for the pull-up array |

## Verification
A wrong sequencer state shows up within one cycle as a steering or tap select that does not match the phase implied by the write strobes seen so far. A miscounted settle or evaluation step shifts the length of the busy window by whole multiples of the step length, so the bench compares that length exactly. A synchronizer or qualification fault shows up at done as a stored code that is off from the comparator threshold, or as a sweep stopped early by a one-cycle glitch. Faults in the holding registers or in the range flag appear as wrong held codes or a wrong flag at the done pulse, or at the clear two cycles into the next run.

// File: rtl/termcal_pkg.sv
package termcal_pkg;

    localparam int NUM_PHASES = 2;

    typedef enum logic [2:0] {
        STEER_OFF = 3'b000,
        STEER_RX  = 3'b001,
        STEER_TX  = 3'b010
    } steer_e;

    typedef enum logic [0:0] {
        PH_RX = 1'b0,
        PH_TX = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_SETTLE,
        S_EVAL,
        S_STORE,
        S_DONE
    } state_e;

    typedef struct packed {
        logic   busy;
        logic   done;
        logic   clr_regs;
        logic   wr_code;
        logic   wr_miss;
        logic   flush;
        logic   code_zero;
        logic   code_inc;
        logic   settle_run;
        phase_e phase;
    } seq_ctrl_t;

    function automatic steer_e steer_for(input logic active, input phase_e ph);
        if (!active)          return STEER_OFF;
        else if (ph == PH_RX) return STEER_RX;
        else                  return STEER_TX;
    endfunction

    function automatic logic [NUM_PHASES-1:0] tap_for(input logic active, input phase_e ph);
        logic [NUM_PHASES-1:0] t;
        t = '0;
        if (active) t[ph] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/termcal_sync.sv
module termcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic din,
    output logic qual
);
    logic [STAGES-1:0] chain_q;
    logic              confirm_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            chain_q   <= '0;
            confirm_q <= 1'b0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            confirm_q <= chain_q[STAGES-1];
        end
    end

    assign qual = chain_q[STAGES-1] & confirm_q;

    // A qualified trip needs two consecutive high raw samples
    assert_two_reads_R5: assert property (@(posedge clk) disable iff (rst)
        qual |-> ($past(din, STAGES) && $past(din, STAGES + 1)));

endmodule

// File: rtl/termcal_ramp.sv
module termcal_ramp #(
    parameter int CODE_W   = 6,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                code_zero,
    input  logic                code_inc,
    input  logic                settle_run,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic [CODE_W-1:0]   code,
    output logic                code_full,
    output logic                settle_done
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0]   code_q;
    logic [SETTLE_W-1:0] wait_q;
    logic [SETTLE_W-1:0] wait_last;

    assign wait_last = (settle_len == '0) ? '0 : settle_len - SETTLE_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !settle_run) wait_q <= '0;
        else                    wait_q <= wait_q + SETTLE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || code_zero) code_q <= '0;
        else if (code_inc)    code_q <= code_q + CODE_W'(1);
    end

    assign code        = code_q;
    assign code_full   = (code_q == CODE_MAX);
    assign settle_done = settle_run && (wait_q >= wait_last);

    // Code only climbs by one or returns to zero
    assert_code_step_R3: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> ((code_q == $past(code_q) + CODE_W'(1)) || (code_q == '0)));

endmodule

// File: rtl/termcal_seq.sv
module termcal_seq
    import termcal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      settle_done,
    input  logic      trip,
    input  logic      code_full,
    output seq_ctrl_t ctrl
);
    state_e state_q, state_d;
    phase_e phase_q, phase_d;
    logic   miss_q;

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        case (state_q)
            S_IDLE:   if (start) begin
                          state_d = S_CLEAR;
                          phase_d = PH_RX;
                      end
            S_CLEAR:  state_d = S_SETTLE;
            S_SETTLE: if (settle_done) state_d = S_EVAL;
            S_EVAL:   if (trip || code_full) state_d = S_STORE;
                      else                   state_d = S_SETTLE;
            S_STORE:  if (phase_q == PH_RX) begin
                          state_d = S_SETTLE;
                          phase_d = PH_TX;
                      end else begin
                          state_d = S_DONE;
                      end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            phase_q <= PH_RX;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (state_q == S_EVAL) miss_q <= code_full & ~trip;
        end
    end

    always_comb begin
        ctrl.busy       = (state_q != S_IDLE) && (state_q != S_DONE);
        ctrl.done       = (state_q == S_DONE);
        ctrl.clr_regs   = (state_q == S_CLEAR);
        ctrl.wr_code    = (state_q == S_STORE);
        ctrl.wr_miss    = (state_q == S_STORE) && miss_q;
        ctrl.flush      = (state_q == S_CLEAR) || (state_q == S_STORE);
        ctrl.code_zero  = (state_q != S_SETTLE) && (state_q != S_EVAL);
        ctrl.code_inc   = (state_q == S_EVAL) && !trip && !code_full;
        ctrl.settle_run = (state_q == S_SETTLE);
        ctrl.phase      = phase_q;
    end

    // Completion only directly after a code write
    assert_done_after_store_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.done |-> $past(ctrl.wr_code));

    // A write is only ever caused by a trip or a full sweep
    assert_wr_cause_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.wr_code |-> $past(trip || code_full));

endmodule

// File: rtl/termcal_hold.sv
module termcal_hold
    import termcal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 clr,
    input  logic                                 wr,
    input  logic                                 wr_miss,
    input  phase_e                               phase,
    input  logic [CODE_W-1:0]                    code,
    output logic [NUM_PHASES-1:0][CODE_W-1:0]    slots,
    output logic                                 range_err
);
    logic err_q;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_slot
        logic [CODE_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst || clr)                         val_q <= '0;
            else if (wr && (int'(phase) == p))      val_q <= code;
        end

        assign slots[p] = val_q;

        assert_store_value_R4: assert property (@(posedge clk) disable iff (rst)
            (wr && (int'(phase) == p)) |=> (val_q == $past(code)));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)          err_q <= 1'b0;
        else if (wr && wr_miss)  err_q <= 1'b1;
    end

    assign range_err = err_q;

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr) |=> err_q);

endmodule

// File: rtl/termcal_ctrl.sv
module termcal_ctrl
    import termcal_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SETTLE_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmp_in,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                busy,
    output logic                done,
    output logic                range_error,
    output logic [2:0]          steer_sel,
    output logic [1:0]          cmp_tap_sel,
    output logic [CODE_W-1:0]   cal_code,
    output logic                code_clr,
    output logic                code_wr,
    output logic [CODE_W-1:0]   rx_term_code,
    output logic [CODE_W-1:0]   tx_pd_code,
    output logic [CODE_W-1:0]   tx_pu_code
);
    seq_ctrl_t                          ctrl;
    logic                               trip;
    logic                               code_full;
    logic                               settle_done;
    logic [NUM_PHASES-1:0][CODE_W-1:0]  slots;

    termcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .flush (ctrl.flush),
        .din   (cmp_in),
        .qual  (trip)
    );

    termcal_ramp #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_ramp (
        .clk         (clk),
        .rst         (rst),
        .code_zero   (ctrl.code_zero),
        .code_inc    (ctrl.code_inc),
        .settle_run  (ctrl.settle_run),
        .settle_len  (settle_len),
        .code        (cal_code),
        .code_full   (code_full),
        .settle_done (settle_done)
    );

    termcal_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .settle_done (settle_done),
        .trip        (trip),
        .code_full   (code_full),
        .ctrl        (ctrl)
    );

    termcal_hold #(.CODE_W(CODE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .clr       (ctrl.clr_regs),
        .wr        (ctrl.wr_code),
        .wr_miss   (ctrl.wr_miss),
        .phase     (ctrl.phase),
        .code      (cal_code),
        .slots     (slots),
        .range_err (range_error)
    );

    assign busy         = ctrl.busy;
    assign done         = ctrl.done;
    assign code_clr     = ctrl.clr_regs;
    assign code_wr      = ctrl.wr_code;
    assign steer_sel    = steer_for(ctrl.busy, ctrl.phase);
    assign cmp_tap_sel  = tap_for(ctrl.busy, ctrl.phase);
    assign rx_term_code = slots[PH_RX];
    assign tx_pd_code   = slots[PH_TX];
    assign tx_pu_code   = slots[PH_TX];

    // Sequencer idle implies the ramp sits at zero
    assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cal_code == '0));

    // Single-cycle strobes
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        code_wr |=> !code_wr);

endmodule

// File: tb/tb_termcal_ctrl.sv
`timescale 1ns/1ps
module tb_termcal_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cmp_in;
    logic [3:0] settle_len = 4'd4;
    logic       busy, done, range_error, code_clr, code_wr;
    logic [2:0] steer_sel;
    logic [1:0] cmp_tap_sel;
    logic [5:0] cal_code, rx_term_code, tx_pd_code, tx_pu_code;

    int  thr_rx = 64;
    int  thr_tx = 64;
    bit  glitch = 1'b0;
    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    // Comparator model: trips once the live code reaches the phase threshold
    assign cmp_in = glitch |
                    ((steer_sel == 3'b001) ? (int'(cal_code) >= thr_rx) :
                     (steer_sel == 3'b010) ? (int'(cal_code) >= thr_tx) : 1'b0);

    termcal_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cmp_in       (cmp_in),
        .settle_len   (settle_len),
        .busy         (busy),
        .done         (done),
        .range_error  (range_error),
        .steer_sel    (steer_sel),
        .cmp_tap_sel  (cmp_tap_sel),
        .cal_code     (cal_code),
        .code_clr     (code_clr),
        .code_wr      (code_wr),
        .rx_term_code (rx_term_code),
        .tx_pd_code   (tx_pd_code),
        .tx_pu_code   (tx_pu_code)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int stored_of(input int thr);
        return (thr > 63) ? 63 : thr;
    endfunction

    function automatic int busy_len(input int trx, input int ttx, input int st);
        int eff;
        eff = (st == 0) ? 1 : st;
        return 3 + (stored_of(trx) + 1 + stored_of(ttx) + 1) * (eff + 1);
    endfunction

    task automatic run_cal(input int trx, input int ttx, input int st, input bit glitch_en, input bit mid_start);
        int busy_n = 0, wr_n = 0, clr_n = 0, sel_bad = 0, k = 0;
        bit timed_out = 1'b0;
        logic [2:0] exp_steer;
        logic [1:0] exp_tap;
        thr_rx = trx;
        thr_tx = ttx;
        settle_len = 4'(st);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        forever begin
            if (busy) busy_n++;
            exp_steer = !busy ? 3'b000 : (wr_n == 0) ? 3'b001 : 3'b010;
            exp_tap   = !busy ? 2'b00  : (wr_n == 0) ? 2'b01  : 2'b10;
            if (steer_sel != exp_steer || cmp_tap_sel != exp_tap) sel_bad++;
            if (code_wr) wr_n++;
            if (code_clr) clr_n++;
            if (k == 2) begin
                chk(rx_term_code == 0 && tx_pd_code == 0 && tx_pu_code == 0, "R2", "held codes after clear",
                    int'(rx_term_code) + int'(tx_pd_code), 0);
                chk(range_error == 1'b0, "R2", "range_error after clear", int'(range_error), 0);
            end
            if (glitch_en && k == 30) glitch = 1'b1;
            if (glitch_en && k == 31) glitch = 1'b0;
            if (mid_start && k == 50) start = 1'b1;
            if (mid_start && k == 51) start = 1'b0;
            if (done) break;
            if (k > 20000) begin timed_out = 1'b1; break; end
            @(negedge clk);
            k++;
        end
        chk(!timed_out, "R8", "done reached", k, busy_len(trx, ttx, st));
        chk(busy == 1'b0, "R8", "busy low at done", int'(busy), 0);
        chk(rx_term_code == 6'(stored_of(trx)), "R4", "rx code", int'(rx_term_code), stored_of(trx));
        chk(tx_pd_code == 6'(stored_of(ttx)), "R6", "tx pull-down code", int'(tx_pd_code), stored_of(ttx));
        chk(tx_pu_code == 6'(stored_of(ttx)), "R6", "tx pull-up code", int'(tx_pu_code), stored_of(ttx));
        chk(range_error == (trx > 63 || ttx > 63), "R7", "range_error", int'(range_error), int'(trx > 63 || ttx > 63));
        chk(busy_n == busy_len(trx, ttx, st), mid_start ? "R9" : "R3", "busy cycles", busy_n, busy_len(trx, ttx, st));
        chk(wr_n == 2, "R8", "code_wr pulses", wr_n, 2);
        chk(clr_n == 1, "R2", "code_clr pulses", clr_n, 1);
        chk(sel_bad == 0, "R2", "steer/tap mismatch cycles", sel_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        chk(cal_code == 6'd0, "R3", "code zero when idle", int'(cal_code), 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && range_error == 0, "R1", "status during reset",
            int'({busy, done, range_error}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(steer_sel == 3'b000 && cmp_tap_sel == 2'b00, "R1", "selects idle",
            int'({steer_sel, cmp_tap_sel}), 0);
        chk(cal_code == 0 && rx_term_code == 0 && tx_pd_code == 0 && tx_pu_code == 0, "R1", "codes zero",
            int'(cal_code) + int'(rx_term_code) + int'(tx_pd_code), 0);
        chk(busy == 0 && done == 0 && range_error == 0, "R1", "status after reset",
            int'({busy, done, range_error}), 0);

        run_cal(0, 63, 4, 1'b0, 1'b0);   // R4 code-0 trip, R7 edge at 63 without error
        run_cal(63, 0, 5, 1'b0, 1'b0);
        run_cal(64, 17, 4, 1'b0, 1'b0);  // R7 receive sweep exhausted
        run_cal(25, 64, 6, 1'b0, 1'b0);  // R7 transmit sweep exhausted
        run_cal(10, 20, 4, 1'b0, 1'b0);  // R2 range flag cleared by new start
        run_cal(40, 12, 4, 1'b1, 1'b0);  // R5 single-cycle glitch ignored
        run_cal(30, 30, 7, 1'b0, 1'b1);  // R9 start while busy
        run_cal(64, 64, 0, 1'b0, 1'b0);  // R3 settle 0 acts as 1
        for (int i = 0; i < 6; i++) begin
            run_cal(int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
                    int'($urandom_range(4, 9)), 1'b0, 1'b0);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule